// File: doc/BRIEF.md
# Clock Loss and Lock-Loss Status Monitor

This block watches three clocks from a single monitor clock. The clocks are a reference input, a crystal-path clock and the feedback clock of a PLL. It turns what it sees into a small set of status flags. Each watched clock is first resynchronised into the monitor domain. A watchdog counter per input declares loss of signal quickly when edges stop arriving. The same input must then run cleanly for a much longer settling time before the flag drops. Loss of lock is judged by frequency rather than by phase. The monitor counts rising edges of the reference and feedback clocks over a fixed window of monitor cycles and compares the two counts against a ratio threshold (1000 by default, which is about 1000 ppm). A calibration-busy input is resynchronised and reported as a fourth condition.

Every condition also sets a sticky bit. The sticky bit is cleared by writing 1 to it. Sticky bits that are enabled through a per-bit mask are ORed into an active-high interrupt output. That output is the pull-low enable of an external open-drain pad. The frequency comparison can be paused while the PLL is being reconfigured and restarted afterwards.

Top module: `clkhealth_monitor`

## Requirements
- R1: While reset is asserted and on leaving reset with all clocks running, the status byte reads 0x00 and the interrupt output is 0.
- R2: The reference loss flag (status bit 0) rises within LOS_ASSERT_CYC plus four monitor cycles after the last edge of a stopped reference clock. It stays 0 while edges arrive less than LOS_ASSERT_CYC cycles apart.
- R3: Once set, a loss flag clears only after its clock has toggled without a gap of LOS_ASSERT_CYC cycles for LOS_CLEAR_CYC consecutive cycles. A shorter return of the clock leaves the flag at 1.
- R4: The crystal-path loss flag (status bit 1) follows the same rules from its own input, independently of the reference flag.
- R5: At the end of each window of WIN_CYC monitor cycles, the lock-loss flag (status bit 2) takes the value |Nref - Nfb| * PPM_DIV > Nref. Nref and Nfb are the rising-edge counts of the two clocks in that window. The flag holds until the next window ends.
- R6: While the lock-evaluation enable is 0, the lock-loss flag is 0 from the next cycle on and the window restarts. After re-enable, no verdict appears until a full new window has elapsed.
- R7: The calibration flag (status bit 3) equals the calibration-busy input delayed by two monitor cycles.
- R8: Sticky bits (status bits 7:4, in the same order as bits 3:0) are set the cycle after their live condition is 1. They hold until a write with the clear strobe high and a 1 in that bit position. A clear written while the condition is still present leaves the bit set.
- R9: The interrupt output is registered. It is 1 exactly when some sticky bit is 1 and its interrupt-enable bit was 1 in the previous cycle. A masked condition does not raise it.
- R10: The status byte is {sticky[3:0], live[3:0]}, with bit order reference loss, crystal loss, lock loss, calibration from the least significant bit up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk_i | input | 1 | Reference clock under watch |
| fb_clk_i | input | 1 | PLL feedback clock for the frequency comparison |
| xtal_clk_i | input | 1 | Crystal-path clock under watch |
| cal_busy_i | input | 1 | Lock acquisition or calibration in progress |
| lock_eval_en_i | input | 1 | 1 runs the frequency comparison, 0 pauses and clears it |
| clr_wr_i | input | 1 | Strobe for write-1-to-clear of sticky bits |
| clr_bits_i | input | 4 | Sticky bits to clear, same order as status bits 3:0 |
| irq_en_i | input | 4 | Per-condition interrupt enable, same order |
| status_o | output | 8 | Status byte: sticky bits high, live flags low |
| irq_pulldown_o | output | 1 | Active-high interrupt, drives the open-drain pull-low enable |

## Verification
The hardest corner is the asymmetry of the loss detector. The bench checks that a stopped reference is flagged inside the watchdog window but not early. It then checks that a brief 200-cycle return does not clear the flag, and that clearing waits for the full settling run. A design that reused one time constant for both directions would clear on that brief return. The lock-loss table holds feedback clocks just inside and just outside the ratio threshold, which catches an inverted or off-by-scale compare. Pause and restart are checked so that a design that kept a stale verdict, or gave one before a full window, fails. The sticky tests cover a write of 1 to other bits, a clear racing a still-present condition, and a masked condition. A design where clear beat set, or where the mask was ignored, shows the wrong status byte or a spurious interrupt.

// File: rtl/clkhealth_pkg.sv
`timescale 1ns/1ps
package clkhealth_pkg;
  // Number of status conditions and their bit positions in the live nibble.
  localparam int unsigned NFLAG        = 4;
  localparam int unsigned NLOS         = 2;
  localparam int unsigned FLG_REF_LOS  = 0;
  localparam int unsigned FLG_XTAL_LOS = 1;
  localparam int unsigned FLG_LOL      = 2;
  localparam int unsigned FLG_CAL      = 3;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/clkhealth_sync2.sv
`timescale 1ns/1ps
module clkhealth_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/clkhealth_los_watch.sv
`timescale 1ns/1ps
module clkhealth_los_watch #(
  parameter int unsigned ASSERT_CYC = 400,
  parameter int unsigned CLEAR_CYC  = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic los_o
);
  localparam int unsigned MW = $clog2(ASSERT_CYC + 1);
  localparam int unsigned OW = $clog2(CLEAR_CYC + 1);
  localparam logic [MW-1:0] MISS_LOAD = MW'(ASSERT_CYC);
  localparam logic [OW-1:0] OK_LAST   = OW'(CLEAR_CYC - 1);

  logic          prev_q;
  logic          los_q, los_n;
  logic [MW-1:0] miss_q, miss_n;
  logic [OW-1:0] ok_q, ok_n;
  logic          edge_seen;
  logic          starved;

  always_comb begin
    edge_seen = lvl_i ^ prev_q;
    starved   = (miss_q == '0);

    // Watchdog: any edge reloads, otherwise count down to zero.
    miss_n = miss_q;
    if (edge_seen) begin
      miss_n = MISS_LOAD;
    end else if (!starved) begin
      miss_n = miss_q - MW'(1);
    end

    // Fast set on starvation, slow clear after a clean run.
    los_n = los_q;
    ok_n  = '0;
    if (starved) begin
      los_n = 1'b1;
    end else if (los_q) begin
      if (ok_q == OK_LAST) begin
        los_n = 1'b0;
      end else begin
        ok_n = ok_q + OW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      miss_q <= MISS_LOAD;
      ok_q   <= '0;
      los_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      miss_q <= miss_n;
      ok_q   <= ok_n;
      los_q  <= los_n;
    end
  end

  assign los_o = los_q;
endmodule

// File: rtl/clkhealth_freq_cmp.sv
`timescale 1ns/1ps
module clkhealth_freq_cmp #(
  parameter int unsigned WIN_CYC = 65536,
  parameter int unsigned PPM_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ref_lvl_i,
  input  logic fb_lvl_i,
  output logic lol_o
);
  localparam int unsigned WW = $clog2(WIN_CYC);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam int unsigned DW = $clog2(PPM_DIV + 1);
  localparam int unsigned PW = CW + DW;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);

  logic          ref_prev_q, fb_prev_q;
  logic [WW-1:0] win_q, win_n;
  logic [CW-1:0] cnt_ref_q, cnt_ref_n;
  logic [CW-1:0] cnt_fb_q, cnt_fb_n;
  logic          lol_q, lol_n;
  logic          ref_rise, fb_rise;
  logic [CW-1:0] diff;
  logic [PW-1:0] scaled;
  logic          too_far;

  always_comb begin
    ref_rise = ref_lvl_i & ~ref_prev_q;
    fb_rise  = fb_lvl_i & ~fb_prev_q;
    diff     = (cnt_ref_q >= cnt_fb_q) ? (cnt_ref_q - cnt_fb_q)
                                       : (cnt_fb_q - cnt_ref_q);
    scaled   = PW'(diff) * PW'(PPM_DIV);
    too_far  = (scaled > PW'(cnt_ref_q));

    win_n     = win_q + WW'(1);
    cnt_ref_n = cnt_ref_q + CW'(ref_rise);
    cnt_fb_n  = cnt_fb_q + CW'(fb_rise);
    lol_n     = lol_q;
    if (!run_i) begin
      win_n     = '0;
      cnt_ref_n = '0;
      cnt_fb_n  = '0;
      lol_n     = 1'b0;
    end else if (win_q == WIN_LAST) begin
      win_n     = '0;
      cnt_ref_n = '0;
      cnt_fb_n  = '0;
      lol_n     = too_far;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q <= 1'b0;
      fb_prev_q  <= 1'b0;
      win_q      <= '0;
      cnt_ref_q  <= '0;
      cnt_fb_q   <= '0;
      lol_q      <= 1'b0;
    end else begin
      ref_prev_q <= ref_lvl_i;
      fb_prev_q  <= fb_lvl_i;
      win_q      <= win_n;
      cnt_ref_q  <= cnt_ref_n;
      cnt_fb_q   <= cnt_fb_n;
      lol_q      <= lol_n;
    end
  end

  assign lol_o = lol_q;
endmodule

// File: rtl/clkhealth_monitor.sv
`timescale 1ns/1ps
module clkhealth_monitor
  import clkhealth_pkg::*;
#(
  parameter int unsigned LOS_ASSERT_CYC = 400,
  parameter int unsigned LOS_CLEAR_CYC  = 1000000,
  parameter int unsigned WIN_CYC        = 65536,
  parameter int unsigned PPM_DIV        = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  input  logic             xtal_clk_i,
  input  logic             cal_busy_i,
  input  logic             lock_eval_en_i,
  input  logic             clr_wr_i,
  input  logic [NFLAG-1:0] clr_bits_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic [2*NFLAG-1:0] status_o,
  output logic             irq_pulldown_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  // Bring the watched clocks and the busy input into the monitor domain.
  logic [3:0] sync_q;
  logic       ref_lvl, fb_lvl, xtal_lvl, cal_lvl;

  clkhealth_sync2 #(.WIDTH(4)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({cal_busy_i, xtal_clk_i, fb_clk_i, ref_clk_i}),
    .q_o   (sync_q)
  );
  assign {cal_lvl, xtal_lvl, fb_lvl, ref_lvl} = sync_q;

  // One loss watchdog per watched input.
  logic [NLOS-1:0] los_lvl;
  logic [NLOS-1:0] los_flag;
  assign los_lvl = {xtal_lvl, ref_lvl};

  for (genvar g = 0; g < NLOS; g++) begin : g_los
    clkhealth_los_watch #(
      .ASSERT_CYC (LOS_ASSERT_CYC),
      .CLEAR_CYC  (LOS_CLEAR_CYC)
    ) u_los (
      .clk   (clk),
      .rst_n (rst_core_n),
      .lvl_i (los_lvl[g]),
      .los_o (los_flag[g])
    );
  end

  logic lol_flag;

  clkhealth_freq_cmp #(
    .WIN_CYC (WIN_CYC),
    .PPM_DIV (PPM_DIV)
  ) u_freq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run_i     (lock_eval_en_i),
    .ref_lvl_i (ref_lvl),
    .fb_lvl_i  (fb_lvl),
    .lol_o     (lol_flag)
  );

  // Live conditions, sticky bits and the interrupt.
  flag_vec_t live;
  flag_vec_t clr_mask;
  flag_vec_t sticky_q, sticky_n;
  logic      irq_q, irq_n;

  always_comb begin
    live               = '0;
    live[FLG_REF_LOS]  = los_flag[0];
    live[FLG_XTAL_LOS] = los_flag[1];
    live[FLG_LOL]      = lol_flag;
    live[FLG_CAL]      = cal_lvl;

    clr_mask = clr_wr_i ? clr_bits_i : '0;
    sticky_n = (sticky_q & ~clr_mask) | live;
    irq_n    = |(sticky_n & irq_en_i);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sticky_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      sticky_q <= sticky_n;
      irq_q    <= irq_n;
    end
  end

  assign status_o       = {sticky_q, live};
  assign irq_pulldown_o = irq_q;
endmodule

// File: rtl/clkhealth_monitor_chk.sv
`timescale 1ns/1ps
module clkhealth_monitor_chk #(
  parameter int unsigned CLEAR_CYC = 1000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cal_busy_i,
  input logic       lock_eval_en_i,
  input logic       clr_wr_i,
  input logic [3:0] clr_bits_i,
  input logic [3:0] irq_en_i,
  input logic [7:0] status_o,
  input logic       irq_pulldown_o
);
  localparam int unsigned HW = $clog2(CLEAR_CYC + 2);
  localparam logic [HW-1:0] HI_SAT = HW'(CLEAR_CYC);

  logic [HW-1:0] hi_cnt_q;
  logic [2:0]    age_q;
  logic          age_done;
  logic [3:0]    keep_mask;

  // Cycles the reference loss flag has been high, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
      age_q    <= '0;
    end else begin
      if (!status_o[0]) begin
        hi_cnt_q <= '0;
      end else if (hi_cnt_q != HI_SAT) begin
        hi_cnt_q <= hi_cnt_q + HW'(1);
      end
      if (age_q != 3'd7) begin
        age_q <= age_q + 3'd1;
      end
    end
  end

  assign age_done  = (age_q == 3'd7);
  assign keep_mask = status_o[7:4] & ~(clr_wr_i ? clr_bits_i : 4'b0000);

  // R3: a loss flag drops only after the full settling run
  assert_los_slow_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> (hi_cnt_q >= HI_SAT));

  // R6: paused evaluation forces the lock-loss flag low
  assert_lol_paused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_eval_en_i |=> !status_o[2]);

  // R7: calibration flag is the busy input two cycles late
  assert_cal_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    age_done |-> (status_o[3] == $past(cal_busy_i, 2)));

  // R8: a live condition sets its sticky bit next cycle
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:0] != 4'b0) |=> ((status_o[7:4] & $past(status_o[3:0])) == $past(status_o[3:0])));

  // R8: sticky bits not cleared stay set
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_mask != 4'b0) |=> ((status_o[7:4] & $past(keep_mask)) == $past(keep_mask)));

  // R9: interrupt follows enabled sticky bits
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulldown_o == |(status_o[7:4] & $past(irq_en_i)));
endmodule

bind clkhealth_monitor clkhealth_monitor_chk #(.CLEAR_CYC(LOS_CLEAR_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cal_busy_i     (cal_busy_i),
  .lock_eval_en_i (lock_eval_en_i),
  .clr_wr_i       (clr_wr_i),
  .clr_bits_i     (clr_bits_i),
  .irq_en_i       (irq_en_i),
  .status_o       (status_o),
  .irq_pulldown_o (irq_pulldown_o)
);

// File: tb/sim_clkhealth_monitor.sv
`timescale 1ns/1ps
module sim_clkhealth_monitor;
  localparam int unsigned LA  = 40;
  localparam int unsigned LC  = 600;
  localparam int unsigned WIN = 4000;
  localparam int unsigned DIV = 10;
  localparam int NV = 5;
  // {feedback half period in monitor cycles, expected lock-loss}
  localparam logic [8:0] VEC [0:NV-1] = '{
    {8'd10, 1'b0}, {8'd12, 1'b1}, {8'd11, 1'b0}, {8'd7, 1'b1}, {8'd10, 1'b0}
  };

  logic       clk, rst_n;
  logic       ref_clk, fb_clk, xtal_clk;
  logic       cal_busy, lock_eval_en, clr_wr;
  logic [3:0] clr_bits, irq_en;
  logic [7:0] status;
  logic       irq;
  logic       ref_run, xtal_run;
  int         fb_half;
  int         errors, checks;
  bit         done;

  clkhealth_monitor #(
    .LOS_ASSERT_CYC (LA),
    .LOS_CLEAR_CYC  (LC),
    .WIN_CYC        (WIN),
    .PPM_DIV        (DIV)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_clk_i      (ref_clk),
    .fb_clk_i       (fb_clk),
    .xtal_clk_i     (xtal_clk),
    .cal_busy_i     (cal_busy),
    .lock_eval_en_i (lock_eval_en),
    .clr_wr_i       (clr_wr),
    .clr_bits_i     (clr_bits),
    .irq_en_i       (irq_en),
    .status_o       (status),
    .irq_pulldown_o (irq)
  );

  // 125 MHz monitor clock
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Watched clocks, offset from the monitor edges; half periods in monitor cycles.
  initial begin
    ref_clk = 1'b0;
    #3;
    forever begin
      #80;
      if (ref_run) ref_clk = ~ref_clk;
    end
  end
  initial begin
    fb_clk = 1'b0;
    #3;
    forever begin
      #(fb_half * 8);
      fb_clk = ~fb_clk;
    end
  end
  initial begin
    xtal_clk = 1'b0;
    #3;
    forever begin
      #80;
      if (xtal_run) xtal_clk = ~xtal_clk;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_sticky(input logic [3:0] bits);
    @(negedge clk);
    clr_wr   = 1'b1;
    clr_bits = bits;
    @(negedge clk);
    clr_wr   = 1'b0;
    clr_bits = 4'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    errors = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; cal_busy = 1'b0; lock_eval_en = 1'b1;
    clr_wr = 1'b0; clr_bits = 4'b0; irq_en = 4'b0;
    ref_run = 1'b1; xtal_run = 1'b1; fb_half = 10;
    wait_cyc(5);
    chk("R1 status in reset", status, 8'h00);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R1 status after reset", status, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);

    // R5: table of feedback rates against the ratio threshold
    for (int i = 0; i < NV; i++) begin
      fb_half = int'(VEC[i][8:1]);
      wait_cyc(9000);
      chk("R5 lock-loss verdict", status[2], VEC[i][0]);
    end

    // R6: pause and restart of the evaluation
    fb_half = 14;
    wait_cyc(9000);
    chk("R6 lock-loss before pause", status[2], 1'b1);
    lock_eval_en = 1'b0;
    wait_cyc(2);
    chk("R6 paused clears flag", status[2], 1'b0);
    wait_cyc(9000);
    chk("R6 stays clear while paused", status[2], 1'b0);
    lock_eval_en = 1'b1;
    wait_cyc(3000);
    chk("R6 no verdict before full window", status[2], 1'b0);
    wait_cyc(6000);
    chk("R6 verdict after restart", status[2], 1'b1);
    fb_half = 10;
    wait_cyc(9000);
    chk("R6 relock", status[2], 1'b0);
    clear_sticky(4'hF);
    chk("R8 clear all", status, 8'h00);

    // R2: fast assertion of reference loss
    ref_run = 1'b0;
    wait_cyc(20);
    chk("R2 not flagged early", status[0], 1'b0);
    wait_cyc(40);
    chk("R2 flagged after stop", status[0], 1'b1);

    // R3: slow clearing
    ref_run = 1'b1;
    wait_cyc(200);
    ref_run = 1'b0;
    wait_cyc(20);
    chk("R3 brief return keeps flag", status[0], 1'b1);
    ref_run = 1'b1;
    wait_cyc(300);
    chk("R3 still settling", status[0], 1'b1);
    wait_cyc(400);
    chk("R3 cleared after settling", status[0], 1'b0);

    // R4: crystal path, independent of reference
    xtal_run = 1'b0;
    wait_cyc(60);
    chk("R4 crystal loss flagged", status[1], 1'b1);
    chk("R4 reference unaffected", status[0], 1'b0);
    xtal_run = 1'b1;
    wait_cyc(700);
    chk("R4 crystal loss cleared", status[1], 1'b0);
    wait_cyc(9000);
    clear_sticky(4'hF);
    chk("R8 clear all again", status, 8'h00);

    // R7, R8, R9, R10: calibration flag, sticky, mask
    irq_en = 4'b0111;
    @(negedge clk);
    cal_busy = 1'b1;
    wait_cyc(1);
    chk("R7 one cycle after busy", status[3], 1'b0);
    wait_cyc(1);
    chk("R7 two cycles after busy", status[3], 1'b1);
    wait_cyc(2);
    chk("R10 byte with calibration", status, 8'h88);
    chk("R9 masked condition no irq", irq, 1'b0);
    cal_busy = 1'b0;
    wait_cyc(4);
    chk("R8 sticky holds", status, 8'h80);
    clear_sticky(4'b0111);
    chk("R8 other bits do not clear", status, 8'h80);
    irq_en = 4'b1111;
    wait_cyc(2);
    chk("R9 enabled sticky raises irq", irq, 1'b1);
    clear_sticky(4'b1000);
    chk("R8 write one clears", status, 8'h00);
    wait_cyc(1);
    chk("R9 irq drops after clear", irq, 1'b0);
    cal_busy = 1'b1;
    wait_cyc(4);
    clear_sticky(4'b1000);
    chk("R8 set wins over clear", status[7], 1'b1);
    cal_busy = 1'b0;
    wait_cyc(4);
    clear_sticky(4'b1000);
    chk("R8 cleared once idle", status, 8'h00);

    // R9: reference loss through the mask
    irq_en = 4'b0001;
    wait_cyc(2);
    chk("R9 irq idle", irq, 1'b0);
    ref_run = 1'b0;
    wait_cyc(60);
    chk("R9 reference loss raises irq", irq, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule